// File: doc/BRIEF.md
# PLL lock and acquisition monitor

This block watches a phase-locked loop from the digital side. The VCO clock reaches it as a single-cycle enable pulse that has already been synchronized into the reference clock domain. The block counts those pulses over a fixed window of reference cycles and compares the total with a programmed target count. The absolute difference is checked against two pairs of hysteretic tolerances. One pair decides whether the loop filter runs in acquisition or tracking mode. The other pair decides whether the loop is reported as locked.

Software controls the block through four small registers. In automatic mode the hardware selects the filter mode, keeps the lock flag up to date, and can raise an interrupt whenever that flag changes. In manual mode software drives the filter mode select directly, the lock flag is held low, and no interrupt is ever raised. While the PLL is off, the measurement is held in reset and both status bits read 0.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset every register reads 0 and `filt_track`, `lock` and `irq` are low. Addresses: 0 = control, 1 = target count, 2 = tracking tolerances, 3 = lock tolerances. Control bits: [0] on, [1] auto, [2] interrupt enable, [3] acq (filter mode, 1 = tracking), [4] lock (read-only), [5] pending (write 1 to clear).
- R2: Each tolerance register holds the enter value in bits [7:0] and the exit value in bits [15:8]. If a write carries an enter value larger than its exit value, the enter value is stored as the exit value.
- R3: While on, the block counts the VCO pulses in each window of WIN_LEN reference cycles. Status is updated only at the clock edge that ends a window. The first update comes at the WIN_LEN-th edge after the write that sets on.
- R4: In auto mode, acq rises when |count − target| ≤ the tracking enter value. It falls only when |count − target| > the tracking exit value.
- R5: In auto mode, lock rises when |count − target| ≤ the lock enter value. It falls only when |count − target| > the lock exit value.
- R6: In auto mode with interrupt enable set, every window-end change of lock, in either direction, sets pending. `irq` follows pending. Writing 1 to control bit 5 clears pending.
- R7: With interrupt enable clear, a lock change leaves pending at 0.
- R8: In manual mode (auto = 0), acq is written by software and drives `filt_track`. Lock stays 0 and pending is never set.
- R9: A control write that moves on from 0 to 1 stores acq as 0, whatever value the write carries.
- R10: While on is 0, acq and lock read 0 and stay 0 across whole windows. Turning the PLL off does not set pending.
- R11: A write that moves auto from 1 to 0 keeps the current acq value as the manual setting. It clears lock without setting pending.
- R12: In auto mode, the acq bit of a control write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_pulse | input | 1 | One pulse per VCO cycle, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*TOL_W | Write data |
| reg_rdata | output | 2*TOL_W | Read data for reg_addr (combinational) |
| filt_track | output | 1 | Loop filter mode select, 1 = tracking |
| lock | output | 1 | Lock status |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
The main stimulus is a VCO pulse pattern that repeats every window length, so any window contains exactly N pulses. N is swept one step at a time from the target up to well past both exit tolerances, back down past them on the other side, and back to the target. Because each step changes N by one, a window that straddles a change still counts either the old or the new value. The bench therefore predicts every status bit exactly from a hysteresis model. The points where the error lies between an enter tolerance and its exit tolerance show hysteresis at work: the same count keeps the old state on the way out and on the way back in, which a single-threshold design would get wrong. Separate sequences cover the first-window timing after power-on, the manual-mode and auto-to-manual transitions, the interrupt enable, and the clamp applied to tolerance writes.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int CNT_W   = 12,
  parameter int TOL_W   = 8,
  parameter int WIN_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vco_pulse,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [2*TOL_W-1:0] reg_wdata,
  output logic [2*TOL_W-1:0] reg_rdata,
  output logic               filt_track,
  output logic               lock,
  output logic               irq
);
  localparam int DW = 2 * TOL_W;
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int CW = (CNT_W > TOL_W) ? CNT_W : TOL_W;

  logic             on_q, auto_q, ie_q, acq_q, lock_q, pend_q;
  logic [CNT_W-1:0] target_q;
  logic [TOL_W-1:0] trk_in_q, trk_out_q, lk_in_q, lk_out_q;
  logic [WW-1:0]    win_q;
  logic [CNT_W-1:0] vco_q;

  logic ctrl_wr, w_on, w_auto, w_ie, w_acq, w_clr;
  assign ctrl_wr = reg_we && (reg_addr == 2'd0);
  assign w_on    = reg_wdata[0];
  assign w_auto  = reg_wdata[1];
  assign w_ie    = reg_wdata[2];
  assign w_acq   = reg_wdata[3];
  assign w_clr   = reg_wdata[5];

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  // measurement window
  logic             win_end;
  logic [CNT_W-1:0] meas, abs_err;
  assign win_end = on_q && (win_q == WW'(WIN_LEN - 1));
  assign meas    = vco_q + CNT_W'(vco_pulse);
  assign abs_err = (meas >= target_q) ? (meas - target_q) : (target_q - meas);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      vco_q <= '0;
    end else if (!on_q || win_end) begin
      win_q <= '0;
      vco_q <= '0;
    end else begin
      win_q <= win_q + WW'(1);
      vco_q <= meas;
    end
  end

  // hysteretic comparisons
  logic trk_hit, trk_miss, lk_hit, lk_miss, acq_eval, lock_eval;
  assign trk_hit   = CW'(abs_err) <= CW'(trk_in_q);
  assign trk_miss  = CW'(abs_err) >  CW'(trk_out_q);
  assign lk_hit    = CW'(abs_err) <= CW'(lk_in_q);
  assign lk_miss   = CW'(abs_err) >  CW'(lk_out_q);
  assign acq_eval  = acq_q  ? !trk_miss : trk_hit;
  assign lock_eval = lock_q ? !lk_miss  : lk_hit;

  logic leave_auto, lock_force0, lock_flip;
  assign leave_auto  = ctrl_wr && !w_auto;
  assign lock_force0 = ctrl_wr && (!w_on || !w_auto);
  assign lock_flip   = win_end && auto_q && !lock_force0 && (lock_eval != lock_q);

  // control and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (ctrl_wr) begin
      on_q   <= w_on;
      auto_q <= w_auto;
      ie_q   <= w_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            acq_q <= 1'b0;
    else if (ctrl_wr && !w_on)             acq_q <= 1'b0;
    else if (ctrl_wr && !on_q)             acq_q <= 1'b0;
    else if (ctrl_wr && !auto_q && !w_auto) acq_q <= w_acq;
    else if (win_end && auto_q && !leave_auto) acq_q <= acq_eval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lock_q <= 1'b0;
    else if (lock_force0)      lock_q <= 1'b0;
    else if (win_end && auto_q) lock_q <= lock_eval;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (lock_flip && ie_q) pend_q <= 1'b1;
    else if (ctrl_wr && w_clr)  pend_q <= 1'b0;
  end

  // configuration registers, enter tolerance clamped to exit tolerance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q  <= '0;
      trk_in_q  <= '0;
      trk_out_q <= '0;
      lk_in_q   <= '0;
      lk_out_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd1: target_q <= reg_wdata[CNT_W-1:0];
        2'd2: begin
          trk_out_q <= reg_wdata[DW-1:TOL_W];
          trk_in_q  <= (reg_wdata[TOL_W-1:0] > reg_wdata[DW-1:TOL_W]) ?
                       reg_wdata[DW-1:TOL_W] : reg_wdata[TOL_W-1:0];
        end
        2'd3: begin
          lk_out_q <= reg_wdata[DW-1:TOL_W];
          lk_in_q  <= (reg_wdata[TOL_W-1:0] > reg_wdata[DW-1:TOL_W]) ?
                      reg_wdata[DW-1:TOL_W] : reg_wdata[TOL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DW'({pend_q, lock_q, acq_q, ie_q, auto_q, on_q});
      2'd1:    reg_rdata = DW'(target_q);
      2'd2:    reg_rdata = {trk_out_q, trk_in_q};
      default: reg_rdata = {lk_out_q, lk_in_q};
    endcase
  end

  assign filt_track = acq_q;
  assign lock       = lock_q;
  assign irq        = pend_q;

  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_in_q <= trk_out_q) && (lk_in_q <= lk_out_q));

  assert_lock_at_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != $past(lock_q)) |-> $past(win_end || ctrl_wr));

  assert_irq_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(auto_q && ie_q && !ctrl_wr) && (lock_q != $past(lock_q))) |-> pend_q);

  assert_manual_no_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |-> !lock_q);

  assert_manual_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_q && !pend_q && !ctrl_wr) |=> !pend_q);

  assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> (!acq_q && !lock_q));
endmodule

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;
  localparam int WIN = 16;
  localparam int TGT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_pulse = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        filt_track, lock, irq;

  int errors = 0, checks = 0;
  int n = TGT;
  int ph = 0;
  int ma = 0, ml = 0;
  bit done = 0;

  pll_lock_monitor #(.CNT_W(8), .TOL_W(8), .WIN_LEN(WIN)) u_pll_lock_monitor (
    .clk(clk), .rst_n(rst_n), .vco_pulse(vco_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .filt_track(filt_track), .lock(lock), .irq(irq));

  always #2 clk = ~clk;

  // pattern with period WIN: any WIN consecutive cycles hold exactly n pulses
  always @(negedge clk) begin
    vco_pulse <= (ph < n);
    ph <= (ph == WIN - 1) ? 0 : ph + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input int v, input bit ie);
    logic [15:0] c;
    int e, old_l;
    n = v;
    repeat (2 * WIN + 3) @(negedge clk);
    e = (v > TGT) ? v - TGT : TGT - v;
    old_l = ml;
    ma = ma ? int'(e <= 4) : int'(e <= 2);
    ml = ml ? int'(e <= 2) : int'(e <= 1);
    rd(2'd0, c);
    chk("R4 acq", c[3], ma);
    chk("R5 lock", c[4], ml);
    if (ie) chk("R6 pending", c[5], int'(ml != old_l));
    else    chk("R7 pending", c[5], 0);
    chk("R4 filt_track", filt_track, ma);
    if (c[5]) wr(2'd0, 16'h0027);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], c);
      chk("R1 reset register", c, 0);
    end
    chk("R1 reset outputs", {filt_track, lock, irq}, 0);

    // R2 clamp and field layout
    wr(2'd2, {8'd2, 8'd5});
    rd(2'd2, c); chk("R2 clamped enter", c, 16'h0202);
    wr(2'd2, {8'd4, 8'd2});
    rd(2'd2, c); chk("R2 tracking pair", c, 16'h0402);
    wr(2'd3, {8'd2, 8'd1});
    rd(2'd3, c); chk("R2 lock pair", c, 16'h0201);
    wr(2'd1, TGT);

    // R3 first evaluation timing after switching on
    wr(2'd0, 16'h0007);
    repeat (15) @(negedge clk);
    chk("R3 lock before window end", lock, 0);
    @(negedge clk);
    chk("R3 lock at window end", lock, 1);
    chk("R4 tracking at window end", filt_track, 1);
    chk("R6 irq on lock rise", irq, 1);
    wr(2'd0, 16'h0027);
    chk("R6 write-one clear", irq, 0);
    ma = 1; ml = 1;

    // R4 R5 R6 hysteresis sweep
    for (int v = TGT + 1; v <= TGT + 6; v++) step(v, 1);
    for (int v = TGT + 5; v >= TGT - 6; v--) step(v, 1);
    for (int v = TGT - 5; v <= TGT; v++) step(v, 1);

    // R7 interrupt enable off
    wr(2'd0, 16'h0003);
    for (int v = TGT + 1; v <= TGT + 3; v++) step(v, 0);
    for (int v = TGT + 2; v >= TGT; v--) step(v, 0);

    // R12 acq bit ignored in auto mode
    wr(2'd0, 16'h0003);
    rd(2'd0, c); chk("R12 acq kept", c[3], 1);

    // R11 auto to manual keeps acq, drops lock quietly
    wr(2'd0, 16'h0005);
    rd(2'd0, c);
    chk("R11 acq kept", c[3], 1);
    chk("R11 lock cleared", c[4], 0);
    chk("R11 no pending", c[5], 0);
    chk("R11 filt_track", filt_track, 1);

    // R8 manual mode
    wr(2'd0, 16'h0005);
    chk("R8 acq written 0", filt_track, 0);
    wr(2'd0, 16'h000D);
    chk("R8 acq written 1", filt_track, 1);
    n = TGT + 5;
    repeat (2 * WIN) @(negedge clk);
    n = TGT;
    repeat (3 * WIN) @(negedge clk);
    rd(2'd0, c);
    chk("R8 lock held low", c[4], 0);
    chk("R8 no interrupt", irq, 0);
    chk("R8 acq unchanged by windows", c[3], 1);

    // R9 switching on clears acq
    wr(2'd0, 16'h000C);
    rd(2'd0, c); chk("R10 acq off", c[3], 0);
    wr(2'd0, 16'h000D);
    rd(2'd0, c); chk("R9 acq cleared on enable", c[3], 0);
    wr(2'd0, 16'h000D);
    rd(2'd0, c); chk("R8 acq set after enable", c[3], 1);

    // R10 switching off
    wr(2'd0, 16'h0007);
    repeat (2 * WIN + 3) @(negedge clk);
    chk("R5 relocked", lock, 1);
    chk("R6 irq on relock", irq, 1);
    wr(2'd0, 16'h0027);
    wr(2'd0, 16'h0006);
    repeat (3 * WIN) @(negedge clk);
    rd(2'd0, c);
    chk("R10 status while off", c, 16'h0006);
    chk("R10 outputs while off", {filt_track, lock, irq}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule